// File: doc/BRIEF.md
# Scanline Sprite Overlay Compositor

The compositor builds one display line in the fill half of an external line buffer. Each line is composed in two phases. First, a stream of 720 background pixels is written to line addresses 0 through 719. Then a sequence of overlay items is drawn over them. Each overlay item is a header followed by a burst of pixel data.

An overlay item is either a scrolled layer or a sprite. Layers may be any length and are not counted against any budget. Sprites are at most 64 pixels wide, and at most 10 are drawn per line. Pixel value zero is transparent and leaves the pixel beneath it unchanged. The block's only output towards the buffer is a stream of write commands: address and data. It never reads the buffer back, because transparency only ever means "skip this write".

A line begins with a `line_start_i` pulse. The producer marks the end of its item list with a `line_end_i` pulse. The compositor raises `done_o` once the last burst has been written. Choosing which sprites touch the line, fetching their data and scanning the line out to the display are handled outside this block.

Top module: `scl_compositor`

## Requirements
- R1: After reset, `wr_en_o`, `done_o` and `overflow_o` are low. A `line_start_i` pulse clears `done_o` and `overflow_o` and restarts composition.
- R2: After `line_start_i`, the first 720 pixels accepted on `bg_valid_i` are written in arrival order to addresses 0 to 719. Each write appears on the write port one cycle after its pixel is accepted.
- R3: An overlay pixel of value 0 produces no write. Any non-zero overlay pixel produces a write.
- R4: Item pixel k is placed at signed position `hdr_x_i + k`. Positions below 0 or above 719 produce no write.
- R5: Items are drawn in arrival order, so a later item's opaque pixels replace an earlier item's pixels where they overlap.
- R6: A sprite (`hdr_layer_i`=0) header may give a length above 64. Pixels 64 and beyond of that sprite are consumed but never written.
- R7: At most 10 sprite headers are drawn per line, and a header of length 0 still takes a slot. Later sprites have their pixels consumed without writes, and `overflow_o` is set and stays set until the next `line_start_i`.
- R8: A layer item (`hdr_layer_i`=1) is drawn with no width limit if no sprite has yet been accepted on the line. A layer arriving after a sprite is consumed without writes.
- R9: Once `line_end_i` has been seen and no burst is in progress, `done_o` rises, no earlier than one cycle after the line's last write. While `done_o` is high, no write is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| line_start_i | input | 1 | Pulse: begin composing a new line |
| line_end_i | input | 1 | Pulse: no further items for this line |
| bg_valid_i | input | 1 | Background pixel valid |
| bg_pix_i | input | 8 | Background pixel value |
| hdr_valid_i | input | 1 | Item header valid, accepted when no burst is active |
| hdr_layer_i | input | 1 | 1 = layer item, 0 = sprite item |
| hdr_x_i | input | 11 | Signed start position of the item |
| hdr_len_i | input | 10 | Number of pixels in the following burst |
| pix_valid_i | input | 1 | Burst pixel valid |
| pix_i | input | 8 | Burst pixel value, 0 = transparent |
| wr_en_o | output | 1 | Line buffer write strobe |
| wr_addr_o | output | 10 | Line buffer write address |
| wr_data_o | output | 8 | Line buffer write data |
| done_o | output | 1 | Line fully composed |
| overflow_o | output | 1 | At least one sprite was dropped on this line |

## Verification
The hardest state to reach combines three conditions on one line: the sprite budget has just run out, a late layer is being refused, and opaque pixels from several items overlap at both clipped edges. Only then do the drop paths and the ordering rules interact. The bench feeds a single table of items into one line in a chosen order to build that state. The order is two scrolled layers, sprites straddling both edges, an overlapping pair, an over-wide sprite, a refused layer, an empty sprite, and finally two sprites beyond the budget. After every item, the captured line memory is compared with a model computed in the bench. A separate line raises `line_end_i` in the middle of a burst, to show that `done_o` waits for the burst to finish.

// File: rtl/scl_pkg.sv
package scl_pkg;
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_BG   = 2'd1,
    PH_OVL  = 2'd2
  } phase_e;
endpackage

// File: rtl/scl_budget.sv
module scl_budget #(
  parameter int MAX_SPR = 10,
  localparam int CNT_W = $clog2(MAX_SPR + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             req_i,
  output logic             grant_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic             ovf_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             ovf_q;

  assign grant_o = cnt_q < CNT_W'(MAX_SPR);
  assign cnt_o   = cnt_q;
  assign ovf_o   = ovf_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      ovf_q <= 1'b0;
    end else if (clr_i) begin
      cnt_q <= '0;
      ovf_q <= 1'b0;
    end else if (req_i) begin
      if (grant_o) cnt_q <= cnt_q + 1'b1;
      else         ovf_q <= 1'b1;
    end
  end

  assert_budget_cap_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CNT_W'(MAX_SPR));
  assert_ovf_when_full_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ovf_q) |-> cnt_q == CNT_W'(MAX_SPR));
endmodule

// File: rtl/scl_run.sv
module scl_run #(
  parameter int LINE_W = 720,
  parameter int X_W    = 11,
  parameter int LEN_W  = 10,
  parameter int MAX_W  = 64,
  localparam int POS_W  = X_W + 1,
  localparam int IDX_W  = $clog2(MAX_W + 1),
  localparam int ADDR_W = $clog2(LINE_W)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              load_i,
  input  logic [X_W-1:0]    x_i,
  input  logic [LEN_W-1:0]  len_i,
  input  logic              keep_i,
  input  logic              wlim_i,
  input  logic              step_i,
  output logic              busy_o,
  output logic              ok_o,
  output logic [ADDR_W-1:0] addr_o
);
  logic signed [POS_W-1:0] pos_q;
  logic [LEN_W-1:0]        rem_q;
  logic [IDX_W-1:0]        idx_q;
  logic                    busy_q, keep_q, wlim_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      pos_q  <= '0;
      rem_q  <= '0;
      idx_q  <= '0;
      keep_q <= 1'b0;
      wlim_q <= 1'b0;
    end else if (clr_i) begin
      busy_q <= 1'b0;
    end else if (load_i) begin
      busy_q <= len_i != '0;
      pos_q  <= POS_W'($signed(x_i));
      rem_q  <= len_i;
      idx_q  <= '0;
      keep_q <= keep_i;
      wlim_q <= wlim_i;
    end else if (step_i && busy_q) begin
      pos_q <= pos_q + 1'b1;
      rem_q <= rem_q - 1'b1;
      if (idx_q != IDX_W'(MAX_W)) idx_q <= idx_q + 1'b1;
      if (rem_q == LEN_W'(1)) busy_q <= 1'b0;
    end
  end

  logic in_line, in_width;
  assign in_line  = (pos_q >= 0) && (pos_q < $signed(POS_W'(LINE_W)));
  assign in_width = !wlim_q || (idx_q < IDX_W'(MAX_W));
  assign busy_o   = busy_q;
  assign ok_o     = busy_q && keep_q && in_line && in_width;
  assign addr_o   = pos_q[ADDR_W-1:0];

  assert_burst_end_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_q) && !$past(clr_i) |-> $past(rem_q) == LEN_W'(1));
endmodule

// File: rtl/scl_wr_stage.sv
module scl_wr_stage #(
  parameter int LINE_W = 720,
  parameter int PIX_W  = 8,
  localparam int ADDR_W = $clog2(LINE_W)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              ovl_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [PIX_W-1:0]  data_i,
  output logic              en_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [PIX_W-1:0]  data_o
);
  logic ovl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_o   <= 1'b0;
      ovl_q  <= 1'b0;
      addr_o <= '0;
      data_o <= '0;
    end else begin
      en_o   <= en_i;
      ovl_q  <= ovl_i;
      addr_o <= addr_i;
      data_o <= data_i;
    end
  end

  assert_wr_in_range_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_o |-> addr_o < ADDR_W'(LINE_W));
  assert_ovl_opaque_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_o && ovl_q |-> data_o != '0);
endmodule

// File: rtl/scl_compositor.sv
module scl_compositor
  import scl_pkg::*;
#(
  parameter int LINE_W  = 720,
  parameter int PIX_W   = 8,
  parameter int X_W     = 11,
  parameter int LEN_W   = 10,
  parameter int MAX_SPR = 10,
  parameter int MAX_W   = 64,
  localparam int ADDR_W = $clog2(LINE_W),
  localparam int CNT_W  = $clog2(MAX_SPR + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              line_start_i,
  input  logic              line_end_i,
  input  logic              bg_valid_i,
  input  logic [PIX_W-1:0]  bg_pix_i,
  input  logic              hdr_valid_i,
  input  logic              hdr_layer_i,
  input  logic [X_W-1:0]    hdr_x_i,
  input  logic [LEN_W-1:0]  hdr_len_i,
  input  logic              pix_valid_i,
  input  logic [PIX_W-1:0]  pix_i,
  output logic              wr_en_o,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic [PIX_W-1:0]  wr_data_o,
  output logic              done_o,
  output logic              overflow_o
);
  phase_e            phase_q;
  logic [ADDR_W-1:0] bg_cnt_q;
  logic              end_seen_q, done_q;

  logic              run_busy, run_ok, grant;
  logic [ADDR_W-1:0] run_addr;
  logic [CNT_W-1:0]  spr_cnt;

  logic in_ovl, bg_take, hdr_take, pix_take, keep;
  logic wr_en_d;
  logic [ADDR_W-1:0] wr_addr_d;
  logic [PIX_W-1:0]  wr_data_d;

  assign in_ovl   = phase_q == PH_OVL;
  assign bg_take  = (phase_q == PH_BG) && bg_valid_i && !line_start_i;
  assign hdr_take = in_ovl && hdr_valid_i && !run_busy && !end_seen_q && !line_start_i;
  assign pix_take = in_ovl && pix_valid_i && run_busy && !line_start_i;
  // layers only count as underlays: refused once any sprite has been taken
  assign keep     = hdr_layer_i ? (spr_cnt == '0) : grant;

  assign wr_en_d   = bg_take || (pix_take && run_ok && (pix_i != '0));
  assign wr_addr_d = bg_take ? bg_cnt_q : run_addr;
  assign wr_data_d = bg_take ? bg_pix_i : pix_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q    <= PH_IDLE;
      bg_cnt_q   <= '0;
      end_seen_q <= 1'b0;
      done_q     <= 1'b0;
    end else if (line_start_i) begin
      phase_q    <= PH_BG;
      bg_cnt_q   <= '0;
      end_seen_q <= 1'b0;
      done_q     <= 1'b0;
    end else begin
      if (bg_take) begin
        bg_cnt_q <= bg_cnt_q + 1'b1;
        if (bg_cnt_q == ADDR_W'(LINE_W - 1)) phase_q <= PH_OVL;
      end
      if (in_ovl && line_end_i) end_seen_q <= 1'b1;
      if (in_ovl && end_seen_q && !run_busy) done_q <= 1'b1;
    end
  end

  scl_budget #(.MAX_SPR(MAX_SPR)) u_budget (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (line_start_i),
    .req_i   (hdr_take && !hdr_layer_i),
    .grant_o (grant),
    .cnt_o   (spr_cnt),
    .ovf_o   (overflow_o)
  );

  scl_run #(
    .LINE_W (LINE_W),
    .X_W    (X_W),
    .LEN_W  (LEN_W),
    .MAX_W  (MAX_W)
  ) u_run (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (line_start_i),
    .load_i (hdr_take),
    .x_i    (hdr_x_i),
    .len_i  (hdr_len_i),
    .keep_i (keep),
    .wlim_i (!hdr_layer_i),
    .step_i (pix_take),
    .busy_o (run_busy),
    .ok_o   (run_ok),
    .addr_o (run_addr)
  );

  scl_wr_stage #(.LINE_W(LINE_W), .PIX_W(PIX_W)) u_wr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (wr_en_d),
    .ovl_i  (!bg_take),
    .addr_i (wr_addr_d),
    .data_i (wr_data_d),
    .en_o   (wr_en_o),
    .addr_o (wr_addr_o),
    .data_o (wr_data_o)
  );

  assign done_o = done_q;

  assert_done_quiet_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |-> !wr_en_o);
  assert_done_after_end_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_q) |-> end_seen_q && !run_busy);
endmodule

// File: tb/scl_compositor_bench.sv
module scl_compositor_bench;
  localparam int LINE_W = 720;
  localparam int NVEC   = 15;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        line_start_i = 1'b0, line_end_i = 1'b0;
  logic        bg_valid_i = 1'b0;
  logic [7:0]  bg_pix_i = '0;
  logic        hdr_valid_i = 1'b0, hdr_layer_i = 1'b0;
  logic [10:0] hdr_x_i = '0;
  logic [9:0]  hdr_len_i = '0;
  logic        pix_valid_i = 1'b0;
  logic [7:0]  pix_i = '0;
  logic        wr_en_o, done_o, overflow_o;
  logic [9:0]  wr_addr_o;
  logic [7:0]  wr_data_o;

  always #10 clk = ~clk;

  scl_compositor u_scl_compositor (
    .clk_i(clk), .rst_ni(rst_ni), .line_start_i(line_start_i), .line_end_i(line_end_i),
    .bg_valid_i(bg_valid_i), .bg_pix_i(bg_pix_i), .hdr_valid_i(hdr_valid_i),
    .hdr_layer_i(hdr_layer_i), .hdr_x_i(hdr_x_i), .hdr_len_i(hdr_len_i),
    .pix_valid_i(pix_valid_i), .pix_i(pix_i), .wr_en_o(wr_en_o), .wr_addr_o(wr_addr_o),
    .wr_data_o(wr_data_o), .done_o(done_o), .overflow_o(overflow_o)
  );

  logic [7:0] dut_mem [LINE_W];
  logic [7:0] ref_mem [LINE_W];
  always @(posedge clk) if (wr_en_o && wr_addr_o < 10'(LINE_W)) dut_mem[wr_addr_o] <= wr_data_o;

  int n_chk = 0, n_fail = 0;
  int spr_acc = 0;

  // {layer, x (signed), len, seed}
  localparam logic [29:0] VEC [NVEC] = '{
    {1'b1, 11'(-100), 10'd720, 8'd3},   // R8 scrolled layer, R4 left clip
    {1'b1, 11'(37),   10'd720, 8'd9},   // R8 second layer, R4 right clip
    {1'b0, 11'(0),    10'd64,  8'd5},
    {1'b0, 11'(-20),  10'd64,  8'd11},  // R4 left edge
    {1'b0, 11'(680),  10'd64,  8'd17},  // R4 right edge
    {1'b0, 11'(30),   10'd64,  8'd23},  // R5 overlaps item 2
    {1'b0, 11'(300),  10'd100, 8'd29},  // R6 over-wide
    {1'b1, 11'(0),    10'd720, 8'd31},  // R8 refused layer
    {1'b0, 11'(719),  10'd1,   8'd1},
    {1'b0, 11'(400),  10'd0,   8'd2},   // R7 empty sprite takes a slot
    {1'b0, 11'(500),  10'd64,  8'd4},
    {1'b0, 11'(-64),  10'd64,  8'd6},   // R4 fully clipped
    {1'b0, 11'(600),  10'd64,  8'd8},   // tenth sprite
    {1'b0, 11'(100),  10'd64,  8'd12},  // R7 dropped
    {1'b0, 11'(200),  10'd40,  8'd14}   // R7 dropped
  };

  function automatic logic [7:0] pix_of(int seed, int i);
    logic [7:0] v;
    v = 8'((seed * 37 + i * 11 + (i >> 3)) & 255);
    if ((i + seed) % 4 == 0) v = 8'h00;
    return v;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic cmp_mem(input string req);
    int bad = 0, first = -1;
    for (int i = 0; i < LINE_W; i++)
      if (dut_mem[i] !== ref_mem[i]) begin
        bad++;
        if (first < 0) first = i;
      end
    if (bad != 0)
      chk(1'b0, req, int'(dut_mem[first]), int'(ref_mem[first]));
    else
      chk(1'b1, req, 0, 0);
  endtask

  task automatic start_line(input int ln);
    @(negedge clk);
    line_start_i = 1'b1;
    @(negedge clk);
    line_start_i = 1'b0;
    spr_acc = 0;
    for (int i = 0; i < LINE_W; i++) begin
      bg_valid_i = 1'b1;
      bg_pix_i   = 8'((i * 3 + ln * 17) & 255);
      ref_mem[i] = bg_pix_i;
      @(negedge clk);
    end
    bg_valid_i = 1'b0;
  endtask

  // end_at: pixel index at which line_end_i is raised, -1 for none
  task automatic send_item(input bit layer, input int x, input int len, input int seed,
                           input int end_at);
    bit keep;
    keep = layer ? (spr_acc == 0) : (spr_acc < 10);
    if (!layer && spr_acc < 10) spr_acc++;
    hdr_valid_i = 1'b1;
    hdr_layer_i = layer;
    hdr_x_i     = 11'(x);
    hdr_len_i   = 10'(len);
    @(negedge clk);
    hdr_valid_i = 1'b0;
    for (int i = 0; i < len; i++) begin
      pix_valid_i = 1'b1;
      pix_i       = 8'(pix_of(seed, i));
      line_end_i  = (i == end_at);
      if (keep && (layer || i < 64) && pix_i != 0 && x + i >= 0 && x + i < LINE_W)
        ref_mem[x + i] = pix_i;
      @(negedge clk);
    end
    pix_valid_i = 1'b0;
    line_end_i  = 1'b0;
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic end_line();
    line_end_i = 1'b1;
    @(negedge clk);
    line_end_i = 1'b0;
    @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    #(20 * 200000);
    chk(1'b0, "watchdog", 0, 1);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    for (int i = 0; i < LINE_W; i++) dut_mem[i] = '0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(wr_en_o == 1'b0, "R1 wr_en after reset", int'(wr_en_o), 0);
    chk(done_o == 1'b0, "R1 done after reset", int'(done_o), 0);
    chk(overflow_o == 1'b0, "R1 overflow after reset", int'(overflow_o), 0);
    rst_ni = 1'b1;
    @(negedge clk);

    // line 1: table walk, memory compared after every item
    start_line(1);
    @(negedge clk);
    cmp_mem("R2 background line 1");
    for (int v = 0; v < NVEC; v++) begin
      send_item(VEC[v][29], int'($signed(VEC[v][28:18])), int'(VEC[v][17:8]),
                int'(VEC[v][7:0]), -1);
      cmp_mem($sformatf("R3/R4/R5/R6/R7/R8 item %0d", v));
    end
    chk(overflow_o == 1'b1, "R7 overflow set", int'(overflow_o), 1);
    chk(done_o == 1'b0, "R9 done before end", int'(done_o), 0);
    end_line();
    chk(done_o == 1'b1, "R9 done after end", int'(done_o), 1);

    // line 2: restart clears flags; background only
    start_line(2);
    chk(done_o == 1'b0, "R1 done cleared by line start", int'(done_o), 0);
    chk(overflow_o == 1'b0, "R1 overflow cleared by line start", int'(overflow_o), 0);
    end_line();
    cmp_mem("R2 background line 2");
    chk(done_o == 1'b1, "R9 done with no items", int'(done_o), 1);

    // line 3: line_end_i raised mid-burst; done waits for burst
    start_line(3);
    send_item(1'b0, 200, 20, 7, -1);
    hdr_valid_i = 1'b1;
    hdr_layer_i = 1'b0;
    hdr_x_i     = 11'(210);
    hdr_len_i   = 10'd30;
    spr_acc++;
    @(negedge clk);
    hdr_valid_i = 1'b0;
    for (int i = 0; i < 30; i++) begin
      pix_valid_i = 1'b1;
      pix_i       = pix_of(13, i);
      line_end_i  = (i == 5);
      if (pix_i != 0) ref_mem[210 + i] = pix_i;
      if (i == 12) chk(done_o == 1'b0, "R9 done held during burst", int'(done_o), 0);
      @(negedge clk);
    end
    pix_valid_i = 1'b0;
    line_end_i  = 1'b0;
    @(negedge clk);
    @(negedge clk);
    chk(done_o == 1'b1, "R9 done after burst", int'(done_o), 1);
    cmp_mem("R5 line 3 final");

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule